// File: doc/BRIEF.md
# Voice-memory command sequencer

This block sits between a host-side request port and a byte-level I2C master. It serves a serial voice record/playback memory. Each request names one operation: power up, power down, halt, play, record, message cue, configuration load, status read, or a digital read, write or erase. The block expands that operation into the exact series of start, repeated-start, byte-write, byte-read and stop steps the memory expects. It computes the command byte and appends a 16-bit start address when one is asked for. Digital operations are wrapped in the mode-entry and mode-exit commands. The sequencer also polls the READY status bit after a digital write, and waits for a low-then-high pulse on the memory's row-clock pin after a digital erase.

Write payload enters, and read payload leaves, through valid/ready byte streams. A byte is transferred in a cycle where both valid and ready are high. While `rdata_valid` is high and `rdata_ready` is low, `rdata` is held, and no further byte is fetched from the bus. When `wdata_valid` is low, the sequencer simply waits before its next byte write. The request port takes one request per idle period. `busy` stays high until a one-cycle `done` pulse, and `err_code` gives the result.

Top module: `vm_cmd_seq`

## Requirements
- R1: After reset `busy`, `done`, `m_cmd_valid` and `err_code` are 0, and `req_ready` is 1.
- R2: The command byte is built as bit 7 power-up, bit 6 digital-mode, bits 6:3 OR-ed with a 4-bit function code, and bits 1:0 a register action. Function codes are halt 0, record 2, play 5, cue 7, write 9, erase 10 and read 12. Register actions are none 0, address 1, config-A 2 and config-B 3. The resulting bytes are power-up 0x80, power-down 0x00, halt 0x80, play 0xA8, record 0x90 and cue 0xB8, each +1 when an address is carried.
- R3: A command step is START, PUT 0x80, PUT command. When an address is requested (play, record and cue only), it continues with PUT address[15:8] and then PUT address[7:0]. It ends with STOP. Master op codes are START 0, RSTART 1, PUT 2, GET 3 and STOP 4. `m_byte` is 0 on non-PUT ops, and `m_ack` is 0 except on an acknowledging GET.
- R4: A status read is START, PUT 0x81, GET(ack), GET(ack), GET(no ack), STOP. The three bytes land in `stat_byte`, `stat_addr[15:8]` and `stat_addr[7:0]`.
- R5: A configuration load issues command 0x82 carrying `req_cfg0`, then command 0x83 carrying `req_cfg1`. Each uses the addressed framing of R3.
- R6: A digital write runs the following sequence:
  1. Entry command 0xC0.
  2. START, PUT 0x80, PUT 0xC8 (0xC9 with address), the optional address, then `req_len` bytes taken from the write stream, then STOP.
  3. Status reads (R4) repeated until status bit 5 (READY) is 1.
  4. Exit command 0x40.
- R7: A digital read runs the following sequence:
  1. 0xC0.
  2. START, PUT 0x80, PUT 0xE0 (0xE1 with address), the optional address, RSTART, PUT 0x81, then `req_len` GETs, each acknowledged except the last, then STOP.
  3. 0x40.

  Each received byte is offered on the read stream in order, and the next GET waits for the handshake.
- R8: A digital erase runs the following sequence:
  1. 0xC0.
  2. 0xD0 (0xD1 with address).
  3. 0x80.
  4. A wait for a falling and then a rising edge of the two-stage-synchronised `rac_in`.
  5. 0x40.

  No bus activity occurs during the wait.
- R9: A digital read or write with `req_len` above 256 causes no bus activity and completes with `err_code` = 3. A length of exactly 256 is accepted.
- R10: A PUT answered with `m_nack` makes the next bus op a STOP. The request then ends with `err_code` = 1.
- R11: If the READY poll or the row-clock wait lasts `tmo_limit` cycles, the request ends with `err_code` = 2 and no exit command is sent.
- R12: `busy` rises the cycle after a request is taken. `done` is a single-cycle pulse. A master op held without `m_cmd_ready` keeps its op and byte stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_op | input | 4 | Operation: 0 pwr-up, 1 pwr-down, 2 play, 3 record, 4 cue, 5 halt, 6 config, 7 status, 8 dig-read, 9 dig-write, 10 dig-erase |
| req_use_addr | input | 1 | Carry an explicit start address |
| req_addr | input | 16 | Start address |
| req_len | input | LEN_W | Payload length in bytes |
| req_cfg0 | input | 16 | First configuration word |
| req_cfg1 | input | 16 | Second configuration word |
| tmo_limit | input | TMO_W | Poll and row-clock wait limit in cycles |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 missing ACK, 2 timeout, 3 length rejected |
| stat_byte | output | 8 | Last status byte read |
| stat_addr | output | 16 | Last address read |
| wdata_valid | input | 1 | Write byte present |
| wdata_ready | output | 1 | Write byte taken |
| wdata | input | 8 | Write byte |
| rdata_valid | output | 1 | Read byte present |
| rdata_ready | input | 1 | Read byte taken |
| rdata | output | 8 | Read byte |
| m_cmd_valid | output | 1 | Master op present |
| m_cmd_ready | input | 1 | Master op taken |
| m_op | output | 3 | Master op code |
| m_byte | output | 8 | Byte to send |
| m_ack | output | 1 | Acknowledge the byte to be received |
| m_done | input | 1 | Master op finished |
| m_rbyte | input | 8 | Received byte |
| m_nack | input | 1 | Sent byte was not acknowledged |
| rac_in | input | 1 | Row-clock pin of the memory, asynchronous |

## Verification
The assertions cover the handshake rules on every cycle:
- a master op and a read byte are held steady under back-pressure;
- `done` lasts one cycle;
- no op is issued while idle;
- a refused byte is followed by a STOP;
- an expired timeout stays expired.

The exact byte order of each operation can only be shown by the bench's scenarios, which log every master op and compare the log to a sequence built from the requirements. The same applies to the ACK pattern on reads, the READY poll count, the pause for the row-clock pulse, the 256/257 length boundary and the timeout abort.

// File: rtl/vm_seq_pkg.sv
package vm_seq_pkg;

  typedef enum logic [3:0] {
    OP_PWR_UP = 4'd0, OP_PWR_DN = 4'd1, OP_PLAY = 4'd2, OP_REC = 4'd3,
    OP_CUE = 4'd4, OP_HALT = 4'd5, OP_CFG = 4'd6, OP_STATUS = 4'd7,
    OP_DREAD = 4'd8, OP_DWRITE = 4'd9, OP_DERASE = 4'd10
  } op_e;

  typedef enum logic [2:0] {
    M_START = 3'd0, M_RSTART = 3'd1, M_PUT = 3'd2, M_GET = 3'd3, M_STOP = 3'd4
  } mop_e;

  typedef enum logic [1:0] {TK_CMD, TK_STATUS, TK_RAC, TK_END} tk_e;
  typedef enum logic [1:0] {DX_NONE, DX_WRITE, DX_READ} dx_e;

  typedef struct packed {
    tk_e         kind;
    logic [7:0]  cmd;
    logic        with_addr;
    logic [15:0] addr;
    dx_e         dx;
    logic        poll;
  } step_t;

  localparam logic [7:0] DEV_WR = 8'h80;
  localparam logic [7:0] DEV_RD = 8'h81;
  localparam int READY_BIT = 5;

  localparam logic [3:0] FN_HALT  = 4'd0;
  localparam logic [3:0] FN_REC   = 4'd2;
  localparam logic [3:0] FN_PLAY  = 4'd5;
  localparam logic [3:0] FN_CUE   = 4'd7;
  localparam logic [3:0] FN_WRITE = 4'd9;
  localparam logic [3:0] FN_ERASE = 4'd10;
  localparam logic [3:0] FN_READ  = 4'd12;

  localparam logic [1:0] RA_NONE = 2'd0;
  localparam logic [1:0] RA_ADDR = 2'd1;
  localparam logic [1:0] RA_CFGA = 2'd2;
  localparam logic [1:0] RA_CFGB = 2'd3;

  localparam logic [1:0] ERR_NONE = 2'd0;
  localparam logic [1:0] ERR_NACK = 2'd1;
  localparam logic [1:0] ERR_TMO  = 2'd2;
  localparam logic [1:0] ERR_LEN  = 2'd3;

  function automatic logic [7:0] mk_cmd(input logic pu, input logic dab,
                                        input logic [3:0] fn, input logic [1:0] ra);
    return {pu, 7'b0} | {1'b0, dab, 6'b0} | {1'b0, fn, 3'b0} | {6'b0, ra};
  endfunction

  function automatic step_t cmd_step(input logic [7:0] c, input logic wa,
                                     input logic [15:0] a, input dx_e d);
    step_t s;
    s.kind = TK_CMD; s.cmd = c; s.with_addr = wa; s.addr = a; s.dx = d; s.poll = 1'b0;
    return s;
  endfunction

endpackage

// File: rtl/vm_seq_plan.sv
module vm_seq_plan
  import vm_seq_pkg::*;
(
  input  op_e         op,
  input  logic        use_addr,
  input  logic [2:0]  phase,
  input  logic [15:0] addr,
  input  logic [15:0] cfg0,
  input  logic [15:0] cfg1,
  output step_t       step
);
  logic [1:0] ra;
  step_t enter_s, exit_s, end_s;

  always_comb begin
    ra = use_addr ? RA_ADDR : RA_NONE;
    end_s = '{kind: TK_END, cmd: 8'h00, with_addr: 1'b0, addr: 16'h0000, dx: DX_NONE, poll: 1'b0};
    enter_s = cmd_step(mk_cmd(1'b1, 1'b1, FN_HALT, RA_NONE), 1'b0, 16'h0000, DX_NONE);
    exit_s  = cmd_step(mk_cmd(1'b0, 1'b1, FN_HALT, RA_NONE), 1'b0, 16'h0000, DX_NONE);
    step = end_s;
    case (op)
      OP_PWR_UP: if (phase == 3'd0) step = cmd_step(mk_cmd(1'b1, 1'b0, FN_HALT, RA_NONE), 1'b0, addr, DX_NONE);
      OP_PWR_DN: if (phase == 3'd0) step = cmd_step(mk_cmd(1'b0, 1'b0, FN_HALT, RA_NONE), 1'b0, addr, DX_NONE);
      OP_HALT:   if (phase == 3'd0) step = cmd_step(mk_cmd(1'b1, 1'b0, FN_HALT, RA_NONE), 1'b0, addr, DX_NONE);
      OP_PLAY:   if (phase == 3'd0) step = cmd_step(mk_cmd(1'b1, 1'b0, FN_PLAY, ra), use_addr, addr, DX_NONE);
      OP_REC:    if (phase == 3'd0) step = cmd_step(mk_cmd(1'b1, 1'b0, FN_REC, ra), use_addr, addr, DX_NONE);
      OP_CUE:    if (phase == 3'd0) step = cmd_step(mk_cmd(1'b1, 1'b0, FN_CUE, ra), use_addr, addr, DX_NONE);
      OP_CFG: case (phase)
        3'd0: step = cmd_step(mk_cmd(1'b1, 1'b0, FN_HALT, RA_CFGA), 1'b1, cfg0, DX_NONE);
        3'd1: step = cmd_step(mk_cmd(1'b1, 1'b0, FN_HALT, RA_CFGB), 1'b1, cfg1, DX_NONE);
        default: step = end_s;
      endcase
      OP_STATUS: if (phase == 3'd0) begin
        step = end_s;
        step.kind = TK_STATUS;
      end
      OP_DWRITE: case (phase)
        3'd0: step = enter_s;
        3'd1: step = cmd_step(mk_cmd(1'b1, 1'b0, FN_WRITE, ra), use_addr, addr, DX_WRITE);
        3'd2: begin step = end_s; step.kind = TK_STATUS; step.poll = 1'b1; end
        3'd3: step = exit_s;
        default: step = end_s;
      endcase
      OP_DREAD: case (phase)
        3'd0: step = enter_s;
        3'd1: step = cmd_step(mk_cmd(1'b1, 1'b0, FN_READ, ra), use_addr, addr, DX_READ);
        3'd2: step = exit_s;
        default: step = end_s;
      endcase
      OP_DERASE: case (phase)
        3'd0: step = enter_s;
        3'd1: step = cmd_step(mk_cmd(1'b1, 1'b0, FN_ERASE, ra), use_addr, addr, DX_NONE);
        3'd2: step = cmd_step(mk_cmd(1'b1, 1'b0, FN_HALT, RA_NONE), 1'b0, 16'h0000, DX_NONE);
        3'd3: begin step = end_s; step.kind = TK_RAC; end
        3'd4: step = exit_s;
        default: step = end_s;
      endcase
      default: step = end_s;
    endcase
  end
endmodule

// File: rtl/vm_seq_rac.sv
module vm_seq_rac #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rac_in,
  output logic rac_fall,
  output logic rac_rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rac_in};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rac_fall = prev_q & ~sync_q[SYNC_STAGES-1];
  assign rac_rise = ~prev_q & sync_q[SYNC_STAGES-1];

  a_r8_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rac_fall |=> !rac_fall);
endmodule

// File: rtl/vm_seq_timer.sv
module vm_seq_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clr)               cnt_q <= '0;
    else if (run && !expired)   cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q >= limit);

  a_r11_expiry_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clr && $stable(limit)) |=> (expired || clr || !$stable(limit)));
endmodule

// File: rtl/vm_cmd_seq.sv
module vm_cmd_seq
  import vm_seq_pkg::*;
#(
  parameter int LEN_W       = 10,
  parameter int TMO_W       = 16,
  parameter int MAX_LEN     = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [3:0]       req_op,
  input  logic             req_use_addr,
  input  logic [15:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [15:0]      req_cfg0,
  input  logic [15:0]      req_cfg1,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             busy,
  output logic             done,
  output logic [1:0]       err_code,
  output logic [7:0]       stat_byte,
  output logic [15:0]      stat_addr,
  input  logic             wdata_valid,
  output logic             wdata_ready,
  input  logic [7:0]       wdata,
  output logic             rdata_valid,
  input  logic             rdata_ready,
  output logic [7:0]       rdata,
  output logic             m_cmd_valid,
  input  logic             m_cmd_ready,
  output logic [2:0]       m_op,
  output logic [7:0]       m_byte,
  output logic             m_ack,
  input  logic             m_done,
  input  logic [7:0]       m_rbyte,
  input  logic             m_nack,
  input  logic             rac_in
);
  localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] CNT_ONE   = LEN_W'(1);

  typedef enum logic [3:0] {
    S_IDLE, S_PLAN, S_START, S_WADDR, S_CMD, S_AHI, S_ALO, S_WDATA,
    S_RSTART, S_RADDR, S_GET, S_RDOUT, S_STOP, S_RAC, S_FIN
  } st_e;

  st_e              state;
  op_e              r_op;
  logic             r_use;
  logic [15:0]      r_addr, r_cfg0, r_cfg1;
  logic [LEN_W-1:0] r_len, cnt;
  logic [2:0]       phase;
  logic [1:0]       gidx;
  logic             pend, stat_mode, have_w, saw_fall;
  logic [7:0]       wbuf, rbuf;
  logic             issue, tmo_hit, rac_fall, rac_rise;
  step_t            step;
  st_e              after_hdr;

  vm_seq_plan u_plan (
    .op(r_op), .use_addr(r_use), .phase(phase), .addr(r_addr),
    .cfg0(r_cfg0), .cfg1(r_cfg1), .step(step)
  );

  vm_seq_rac #(.SYNC_STAGES(SYNC_STAGES)) u_rac (
    .clk(clk), .rst_n(rst_n), .rac_in(rac_in), .rac_fall(rac_fall), .rac_rise(rac_rise)
  );

  vm_seq_timer #(.W(TMO_W)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .clr(state == S_IDLE || state == S_PLAN),
    .run(state == S_RAC || (busy && step.poll)),
    .limit(tmo_limit), .expired(tmo_hit)
  );

  assign busy        = (state != S_IDLE);
  assign req_ready   = (state == S_IDLE);
  assign wdata_ready = (state == S_WDATA) && !have_w && !pend;
  assign rdata_valid = (state == S_RDOUT);
  assign rdata       = rbuf;

  always_comb begin
    m_op = M_STOP; m_byte = 8'h00; m_ack = 1'b0; issue = 1'b1;
    case (state)
      S_START:  m_op = M_START;
      S_WADDR:  begin m_op = M_PUT; m_byte = DEV_WR; end
      S_CMD:    begin m_op = M_PUT; m_byte = step.cmd; end
      S_AHI:    begin m_op = M_PUT; m_byte = step.addr[15:8]; end
      S_ALO:    begin m_op = M_PUT; m_byte = step.addr[7:0]; end
      S_WDATA:  begin m_op = M_PUT; m_byte = wbuf; end
      S_RSTART: m_op = M_RSTART;
      S_RADDR:  begin m_op = M_PUT; m_byte = DEV_RD; end
      S_GET:    begin m_op = M_GET; m_ack = stat_mode ? (gidx != 2'd2) : (cnt != CNT_ONE); end
      S_STOP:   m_op = M_STOP;
      default:  issue = 1'b0;
    endcase
  end
  assign m_cmd_valid = issue && !pend && (state != S_WDATA || have_w);

  always_comb begin
    case (step.dx)
      DX_WRITE: after_hdr = (cnt == '0) ? S_STOP : S_WDATA;
      DX_READ:  after_hdr = S_RSTART;
      default:  after_hdr = S_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; r_op <= OP_PWR_UP; r_use <= 1'b0; r_addr <= '0;
      r_cfg0 <= '0; r_cfg1 <= '0; r_len <= '0; cnt <= '0; phase <= '0;
      gidx <= '0; pend <= 1'b0; stat_mode <= 1'b0; have_w <= 1'b0;
      saw_fall <= 1'b0; wbuf <= '0; rbuf <= '0; done <= 1'b0;
      err_code <= ERR_NONE; stat_byte <= '0; stat_addr <= '0;
    end else begin
      done <= 1'b0;
      if (m_cmd_valid && m_cmd_ready) pend <= 1'b1;
      if (wdata_valid && wdata_ready) begin wbuf <= wdata; have_w <= 1'b1; end
      case (state)
        S_IDLE: if (req_valid) begin
          r_op <= op_e'(req_op); r_use <= req_use_addr; r_addr <= req_addr;
          r_len <= req_len; r_cfg0 <= req_cfg0; r_cfg1 <= req_cfg1;
          phase <= '0; err_code <= ERR_NONE;
          if ((op_e'(req_op) == OP_DREAD || op_e'(req_op) == OP_DWRITE) && req_len > LEN_LIMIT) begin
            err_code <= ERR_LEN;
            state    <= S_FIN;
          end else begin
            state <= S_PLAN;
          end
        end
        S_PLAN: case (step.kind)
          TK_CMD:    begin stat_mode <= 1'b0; cnt <= r_len; state <= S_START; end
          TK_STATUS: begin stat_mode <= 1'b1; state <= S_START; end
          TK_RAC:    begin saw_fall <= 1'b0; state <= S_RAC; end
          default:   state <= S_FIN;
        endcase
        S_RAC: begin
          if (tmo_hit) begin
            err_code <= ERR_TMO; state <= S_FIN;
          end else if (saw_fall && rac_rise) begin
            phase <= phase + 3'd1; state <= S_PLAN;
          end else if (rac_fall) begin
            saw_fall <= 1'b1;
          end
        end
        S_RDOUT: if (rdata_ready) begin
          cnt   <= cnt - CNT_ONE;
          state <= (cnt == CNT_ONE) ? S_STOP : S_GET;
        end
        S_FIN: begin done <= 1'b1; state <= S_IDLE; end
        default: if (pend && m_done) begin
          pend <= 1'b0;
          if (m_nack && m_op == M_PUT) begin
            err_code <= ERR_NACK;
            have_w   <= 1'b0;
            state    <= S_STOP;
          end else begin
            case (state)
              S_START:  state <= stat_mode ? S_RADDR : S_WADDR;
              S_WADDR:  state <= S_CMD;
              S_CMD:    state <= step.with_addr ? S_AHI : after_hdr;
              S_AHI:    state <= S_ALO;
              S_ALO:    state <= after_hdr;
              S_WDATA: begin
                have_w <= 1'b0;
                cnt    <= cnt - CNT_ONE;
                if (cnt == CNT_ONE) state <= S_STOP;
              end
              S_RSTART: state <= S_RADDR;
              S_RADDR: begin
                gidx <= '0;
                if (stat_mode)        state <= S_GET;
                else if (cnt == '0)   state <= S_STOP;
                else                  state <= S_GET;
              end
              S_GET: begin
                if (stat_mode) begin
                  case (gidx)
                    2'd0:    stat_byte <= m_rbyte;
                    2'd1:    stat_addr[15:8] <= m_rbyte;
                    default: stat_addr[7:0] <= m_rbyte;
                  endcase
                  gidx  <= gidx + 2'd1;
                  state <= (gidx == 2'd2) ? S_STOP : S_GET;
                end else begin
                  rbuf  <= m_rbyte;
                  state <= S_RDOUT;
                end
              end
              S_STOP: begin
                if (err_code != ERR_NONE) state <= S_FIN;
                else if (step.poll && !stat_byte[READY_BIT]) begin
                  if (tmo_hit) begin err_code <= ERR_TMO; state <= S_FIN; end
                  else state <= S_START;
                end else begin
                  phase <= phase + 3'd1;
                  state <= S_PLAN;
                end
              end
              default: state <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  a_r12_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_cmd_valid && !m_cmd_ready) |=> (m_cmd_valid && $stable(m_op) && $stable(m_byte)));
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r12_busy_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
  a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_valid && !rdata_ready) |=> (rdata_valid && $stable(rdata)));
  a_r9_no_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !m_cmd_valid);
  a_r10_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && m_done && m_nack && m_op == M_PUT) |=> (m_op == M_STOP));
endmodule

// File: tb/tb_vm_cmd_seq.sv
module tb_vm_cmd_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_use_addr = 1'b0;
  logic [3:0] req_op = '0;
  logic [15:0] req_addr = '0, req_cfg0 = '0, req_cfg1 = '0;
  logic [9:0] req_len = '0;
  logic [15:0] tmo_limit = 16'd2000;
  logic busy, done, wdata_ready, rdata_valid, m_cmd_valid, m_ack;
  logic [1:0] err_code;
  logic [7:0] stat_byte, rdata, m_byte;
  logic [15:0] stat_addr;
  logic [2:0] m_op;
  logic wdata_valid, rdata_ready, m_cmd_ready;
  logic [7:0] wdata;
  logic m_done = 1'b0, m_nack = 1'b0, rac_in = 1'b1, clr = 1'b0;
  logic [7:0] m_rbyte = '0;

  int cyc = 0, log_n = 0, polls_left = 0, polls_init = 0, gnum = 0, dcount = 0;
  int nack_at = -1, wptr = 0, rcnt = 0, checks = 0, fails = 0, en = 0;
  bit in_stat = 1'b0;
  logic [11:0] mlog [0:599];
  logic [11:0] exq  [0:599];
  logic [7:0]  rcap [0:299];

  vm_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_use_addr(req_use_addr), .req_addr(req_addr),
    .req_len(req_len), .req_cfg0(req_cfg0), .req_cfg1(req_cfg1),
    .tmo_limit(tmo_limit), .busy(busy), .done(done), .err_code(err_code),
    .stat_byte(stat_byte), .stat_addr(stat_addr),
    .wdata_valid(wdata_valid), .wdata_ready(wdata_ready), .wdata(wdata),
    .rdata_valid(rdata_valid), .rdata_ready(rdata_ready), .rdata(rdata),
    .m_cmd_valid(m_cmd_valid), .m_cmd_ready(m_cmd_ready), .m_op(m_op),
    .m_byte(m_byte), .m_ack(m_ack), .m_done(m_done), .m_rbyte(m_rbyte),
    .m_nack(m_nack), .rac_in(rac_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  assign m_cmd_ready = (cyc % 3) != 0;
  assign wdata_valid = cyc[0];
  assign wdata       = 8'hD0 + wptr[7:0];
  assign rdata_ready = cyc[1];

  // Byte-level master model and stream endpoints
  always_ff @(posedge clk) begin
    cyc    <= cyc + 1;
    m_done <= 1'b0;
    if (clr) begin
      log_n <= 0; polls_left <= polls_init; dcount <= 0; wptr <= 0; rcnt <= 0;
    end else begin
      if (m_cmd_valid && m_cmd_ready) begin
        mlog[log_n] <= {m_op, m_ack, m_byte};
        log_n  <= log_n + 1;
        m_done <= 1'b1;
        m_nack <= (m_op == 3'd2) && (log_n == nack_at);
        if (m_op == 3'd0) begin in_stat <= 1'b1; gnum <= 0; end
        if (m_op == 3'd1) in_stat <= 1'b0;
        if (m_op == 3'd3) begin
          if (in_stat) begin
            case (gnum)
              0: begin
                m_rbyte <= 8'h10 | ((polls_left == 0) ? 8'h20 : 8'h00);
                if (polls_left > 0) polls_left <= polls_left - 1;
              end
              1: m_rbyte <= 8'h5A;
              default: m_rbyte <= 8'h3C;
            endcase
            gnum <= gnum + 1;
          end else begin
            m_rbyte <= 8'hA0 + dcount[7:0];
            dcount  <= dcount + 1;
          end
        end
      end
      if (wdata_valid && wdata_ready) wptr <= wptr + 1;
      if (rdata_valid && rdata_ready) begin rcap[rcnt] <= rdata; rcnt <= rcnt + 1; end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic e_put(input logic [7:0] b); exq[en] = {3'd2, 1'b0, b}; en++; endtask
  task automatic e_op(input logic [2:0] o, input logic a); exq[en] = {o, a, 8'h00}; en++; endtask
  task automatic e_cmd(input logic [7:0] c, input bit wa, input logic [15:0] a);
    e_op(3'd0, 1'b0); e_put(8'h80); e_put(c);
    if (wa) begin e_put(a[15:8]); e_put(a[7:0]); end
    e_op(3'd4, 1'b0);
  endtask
  task automatic e_stat();
    e_op(3'd0, 1'b0); e_put(8'h81); e_op(3'd3, 1'b1); e_op(3'd3, 1'b1); e_op(3'd3, 1'b0); e_op(3'd4, 1'b0);
  endtask

  task automatic check_log(input string req);
    int bad = -1;
    chk(log_n == en, req, "bus op count", log_n, en);
    for (int i = 0; i < en && i < log_n; i++)
      if (bad < 0 && mlog[i] !== exq[i]) bad = i;
    chk(bad < 0, req, "bus op content", (bad < 0) ? 0 : int'(mlog[bad]), (bad < 0) ? 0 : int'(exq[bad]));
  endtask

  task automatic run(input logic [3:0] op, input bit ua, input logic [15:0] a, input int len);
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    en = 0;
    req_op = op; req_use_addr = ua; req_addr = a; req_len = 10'(len); req_valid = 1'b1;
    @(negedge clk) req_valid = 1'b0;
    chk(busy == 1'b1, "R12", "busy after request", busy, 1);
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R12", "done single pulse", done, 0);
  endtask

  localparam logic [28:0] VEC [0:8] = '{
    {4'd0, 1'b0, 16'h0000, 8'h80}, {4'd1, 1'b0, 16'h0000, 8'h00},
    {4'd5, 1'b0, 16'h0000, 8'h80}, {4'd2, 1'b0, 16'h0000, 8'hA8},
    {4'd2, 1'b1, 16'h0123, 8'hA9}, {4'd3, 1'b0, 16'h0000, 8'h90},
    {4'd3, 1'b1, 16'hBEEF, 8'h91}, {4'd4, 1'b0, 16'h0000, 8'hB8},
    {4'd4, 1'b1, 16'h7F01, 8'hB9}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 0 && done == 0 && m_cmd_valid == 0, "R1", "outputs in reset", {busy, done, m_cmd_valid}, 0);
    chk(req_ready == 1 && err_code == 0, "R1", "ready in reset", {req_ready, err_code}, 4);
    rst_n = 1'b1;

    // R2 / R3: command byte table
    foreach (VEC[k]) begin
      run(VEC[k][28:25], VEC[k][24], VEC[k][23:8], 0);
      e_cmd(VEC[k][7:0], VEC[k][24], VEC[k][23:8]);
      check_log(VEC[k][24] ? "R3" : "R2");
      chk(err_code == 0, "R2", "error code", err_code, 0);
    end

    // R5: configuration load
    req_cfg0 = 16'h1357; req_cfg1 = 16'h2468;
    run(4'd6, 1'b0, 16'h0, 0);
    e_cmd(8'h82, 1'b1, 16'h1357); e_cmd(8'h83, 1'b1, 16'h2468);
    check_log("R5");

    // R4: status read
    polls_init = 0;
    run(4'd7, 1'b0, 16'h0, 0);
    e_stat(); check_log("R4");
    chk(stat_byte == 8'h30, "R4", "status byte", stat_byte, 8'h30);
    chk(stat_addr == 16'h5A3C, "R4", "status address", stat_addr, 16'h5A3C);

    // R6: digital write with one not-ready poll
    polls_init = 1;
    run(4'd9, 1'b1, 16'h1234, 3);
    e_cmd(8'hC0, 0, 0);
    e_op(3'd0, 0); e_put(8'h80); e_put(8'hC9); e_put(8'h12); e_put(8'h34);
    e_put(8'hD0); e_put(8'hD1); e_put(8'hD2); e_op(3'd4, 0);
    e_stat(); e_stat(); e_cmd(8'h40, 0, 0);
    check_log("R6");
    chk(wptr == 3, "R6", "write bytes taken", wptr, 3);

    // R7: digital read of four bytes
    polls_init = 0;
    run(4'd8, 1'b0, 16'h0, 4);
    e_cmd(8'hC0, 0, 0);
    e_op(3'd0, 0); e_put(8'h80); e_put(8'hE0); e_op(3'd1, 0); e_put(8'h81);
    e_op(3'd3, 1); e_op(3'd3, 1); e_op(3'd3, 1); e_op(3'd3, 0); e_op(3'd4, 0);
    e_cmd(8'h40, 0, 0);
    check_log("R7");
    chk(rcnt == 4, "R7", "read bytes delivered", rcnt, 4);
    for (int i = 0; i < 4; i++)
      chk(rcap[i] == 8'hA0 + 8'(i), "R7", "read byte", rcap[i], 8'hA0 + i);

    // R9 / R7: boundary length 256 accepted
    run(4'd8, 1'b1, 16'h0100, 256);
    chk(err_code == 0 && log_n == 272, "R9", "len 256 bus ops", log_n, 272);
    chk(mlog[266] == {3'd3, 1'b0, 8'h00}, "R7", "last get not acked", mlog[266], {3'd3, 1'b0, 8'h00});
    chk(rcnt == 256 && rcap[255] == 8'h9F, "R7", "last read byte", rcap[255], 8'h9F);

    // R9: over-length rejection
    run(4'd9, 1'b0, 16'h0, 257);
    chk(log_n == 0, "R9", "no bus ops on reject", log_n, 0);
    chk(err_code == 2'd3, "R9", "reject code", err_code, 3);

    // R8: erase with row-clock pulse
    fork
      run(4'd10, 1'b1, 16'h0040, 0);
      begin
        while (log_n < 14) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(log_n == 14, "R8", "bus quiet while waiting", log_n, 14);
        rac_in = 1'b0;
        repeat (4) @(negedge clk);
        rac_in = 1'b1;
      end
    join
    e_cmd(8'hC0, 0, 0); e_cmd(8'hD1, 1, 16'h0040); e_cmd(8'h80, 0, 0); e_cmd(8'h40, 0, 0);
    check_log("R8");
    chk(err_code == 0, "R8", "erase ok", err_code, 0);

    // R11: row-clock wait times out
    tmo_limit = 16'd40;
    run(4'd10, 1'b0, 16'h0, 0);
    e_cmd(8'hC0, 0, 0); e_cmd(8'hD0, 0, 0); e_cmd(8'h80, 0, 0);
    check_log("R11");
    chk(err_code == 2'd2, "R11", "timeout code", err_code, 2);
    tmo_limit = 16'd2000;

    // R10: missing ACK on the command byte
    nack_at = 2;
    run(4'd2, 1'b0, 16'h0, 0);
    e_op(3'd0, 0); e_put(8'h80); e_put(8'hA8); e_op(3'd4, 0);
    check_log("R10");
    chk(err_code == 2'd1, "R10", "nack code", err_code, 1);
    nack_at = -1;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule